// File: doc/BRIEF.md
# Writable Extension Enable Register

This block is the machine-level register that reports which instruction-set extensions a hart carries and lets machine software switch them on and off while it runs. Each letter A through Z owns one bit of a 26-bit field. The top two bits hold a read-only code for the native register width. The bits drive per-extension enable lines straight into the rest of the hart. A change is therefore live from the cycle after the write.

The block also applies the rules that follow from those bits. When the hypervisor bit is clear, the decoder's "hypervisor access" indication becomes an illegal-instruction flag. The choice between the reduced (E) and full (I) base integer sets is kept legal. The exception PC register is stored here, and its bit 1 is hidden whenever the compressed (C) bit is clear. The stored value survives, so it reappears when C comes back. After an extension is re-enabled, the block makes no promise about that extension's own state, which lives elsewhere.

Software reaches both registers through a simple CSR port: address, write enable, write data and combinational read data. The extension register sits at `ISA_ADDR` (default 0x301) and the exception PC at `EPC_ADDR` (default 0x341).

Top module: `isa_ext_ctl`

## Requirements
- R1: After reset the extension field holds every supported bit, except that E is cleared when I is supported. With the defaults this reads as 0x401411A5 and `ext_en_o` = 0x1411A5 (A=0, C=2, E=4, F=5, H=7, I=8, M=12, S=18, U=20).
- R2: Bits XLEN-1:XLEN-2 of the extension register always read the width code (1 for 32 bits) and ignore writes; bits between it and bit 25 read zero.
- R3: Bits of unsupported letters read zero and never assert on `ext_en_o`, whatever is written.
- R4: A write to `ISA_ADDR` sets each supported non-base bit to the written value, visible on `csr_rdata_o` and `ext_en_o` from the next cycle.
- R5: While bit 7 (H) is clear, `illegal_o` follows `hyp_access_i` in the same cycle; while bit 7 is set, `illegal_o` stays low.
- R6: A write with bit 8 (I) set selects I and clears bit 4 (E). A write with only E set selects E. A write with neither leaves both base bits unchanged.
- R7: A write that would clear bit 2 (C) leaves C set when bit 1 of `next_pc_i` is 1.
- R8: A read of `EPC_ADDR` always returns bit 0 as zero, and returns bit 1 as zero while C is clear.
- R9: The stored exception PC keeps bit 1 as written, including writes made while C is clear, and the stored value reads back in full once C is set again.
- R10: Reads of any other address return zero. Writes to any other address change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_addr_i | input | 12 | CSR address |
| csr_we_i | input | 1 | CSR write enable |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | CSR read data, combinational from the address |
| next_pc_i | input | XLEN | Address of the next instruction |
| hyp_access_i | input | 1 | Current instruction touches a hypervisor CSR or is a hypervisor instruction |
| ext_en_o | output | 26 | Per-letter extension enables |
| illegal_o | output | 1 | Illegal-instruction request for hypervisor use |

## Verification
Register writes land on the clock edge after `csr_we_i` is seen. Each scenario therefore drives a write on a falling edge, lets one rising edge pass, and then reads on the next falling edge. The read data, the width code, the bit-1 masking of the exception PC and `illegal_o` are all combinational from the current state. The bench checks them half a cycle after it changes the address or `hyp_access_i`, with no edge in between. The alignment guard on C and the retention of the stored PC bit are each checked across a write sequence, with each read taken one full edge after the write it depends on.

// File: rtl/isa_ext_pkg.sv
`timescale 1ns/1ps
package isa_ext_pkg;
  localparam int unsigned EXT_W = 26;
  localparam int unsigned EXT_C = 2;
  localparam int unsigned EXT_E = 4;
  localparam int unsigned EXT_H = 7;
  localparam int unsigned EXT_I = 8;

  function automatic logic [1:0] mxl_code(input int unsigned xlen);
    if (xlen == 64) return 2'd2;
    else if (xlen == 128) return 2'd3;
    else return 2'd1;
  endfunction

  function automatic logic [EXT_W-1:0] reset_ext(input logic [EXT_W-1:0] sup);
    logic [EXT_W-1:0] r;
    r = sup;
    if (sup[EXT_I]) r[EXT_E] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/isa_ext_legalize.sv
`timescale 1ns/1ps
module isa_ext_legalize
  import isa_ext_pkg::*;
#(
  parameter logic [EXT_W-1:0] SUPPORTED = 26'h1411B5
) (
  input  logic [EXT_W-1:0] cur_i,
  input  logic [EXT_W-1:0] wr_i,
  input  logic             misalign_i,
  output logic [EXT_W-1:0] nxt_o
);
  always_comb begin
    nxt_o = wr_i & SUPPORTED;
    // base set: I wins, E alone allowed, none keeps previous
    if (nxt_o[EXT_I]) begin
      nxt_o[EXT_E] = 1'b0;
    end else if (!nxt_o[EXT_E]) begin
      nxt_o[EXT_I] = cur_i[EXT_I];
      nxt_o[EXT_E] = cur_i[EXT_E];
    end
    // dropping C with a half-word aligned next pc is refused
    if (cur_i[EXT_C] && !nxt_o[EXT_C] && misalign_i) nxt_o[EXT_C] = 1'b1;
  end
endmodule

// File: rtl/isa_epc_reg.sv
`timescale 1ns/1ps
module isa_epc_reg #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [XLEN-1:1] wdata_i,
  input  logic            c_en_i,
  output logic [XLEN-1:0] rdata_o
);
  logic [XLEN-1:1] epc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) epc_q <= '0;
    else if (we_i) epc_q <= wdata_i;
  end

  // bit 1 hidden on read only; the flop keeps it
  assign rdata_o = {epc_q[XLEN-1:2], epc_q[1] & c_en_i, 1'b0};
endmodule

// File: rtl/isa_hyp_gate.sv
`timescale 1ns/1ps
module isa_hyp_gate (
  input  logic h_en_i,
  input  logic hyp_access_i,
  output logic illegal_o
);
  assign illegal_o = hyp_access_i & ~h_en_i;
endmodule

// File: rtl/isa_ext_ctl.sv
`timescale 1ns/1ps
module isa_ext_ctl
  import isa_ext_pkg::*;
#(
  parameter int unsigned      XLEN      = 32,
  parameter logic [EXT_W-1:0] SUPPORTED = 26'h1411B5,
  parameter logic [11:0]      ISA_ADDR  = 12'h301,
  parameter logic [11:0]      EPC_ADDR  = 12'h341
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [11:0]      csr_addr_i,
  input  logic             csr_we_i,
  input  logic [XLEN-1:0]  csr_wdata_i,
  output logic [XLEN-1:0]  csr_rdata_o,
  input  logic [XLEN-1:0]  next_pc_i,
  input  logic             hyp_access_i,
  output logic [EXT_W-1:0] ext_en_o,
  output logic             illegal_o
);
  localparam logic [1:0]       MXL     = mxl_code(XLEN);
  localparam logic [EXT_W-1:0] EXT_RST = reset_ext(SUPPORTED);

  logic [EXT_W-1:0] ext_q, ext_nxt;
  logic [XLEN-1:0]  isa_rd, epc_rd;
  logic             isa_sel, epc_sel;
  logic             unused_in;

  assign isa_sel   = csr_addr_i == ISA_ADDR;
  assign epc_sel   = csr_addr_i == EPC_ADDR;
  assign unused_in = ^{csr_wdata_i[XLEN-1:EXT_W], next_pc_i[XLEN-1:2], next_pc_i[0]};

  isa_ext_legalize #(.SUPPORTED(SUPPORTED)) u_legal (
    .cur_i      (ext_q),
    .wr_i       (csr_wdata_i[EXT_W-1:0]),
    .misalign_i (next_pc_i[1]),
    .nxt_o      (ext_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_q <= EXT_RST;
    else if (csr_we_i && isa_sel) ext_q <= ext_nxt;
  end

  isa_epc_reg #(.XLEN(XLEN)) u_epc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (csr_we_i && epc_sel),
    .wdata_i (csr_wdata_i[XLEN-1:1]),
    .c_en_i  (ext_q[EXT_C]),
    .rdata_o (epc_rd)
  );

  isa_hyp_gate u_hyp (
    .h_en_i       (ext_q[EXT_H]),
    .hyp_access_i (hyp_access_i),
    .illegal_o    (illegal_o)
  );

  always_comb begin
    isa_rd = '0;
    isa_rd[XLEN-1 -: 2] = MXL;
    isa_rd[EXT_W-1:0]   = ext_q;
  end

  always_comb begin
    if (isa_sel)      csr_rdata_o = isa_rd;
    else if (epc_sel) csr_rdata_o = epc_rd;
    else              csr_rdata_o = '0;
  end

  assign ext_en_o = ext_q;
endmodule

// File: rtl/isa_ext_ctl_chk.sv
`timescale 1ns/1ps
module isa_ext_ctl_chk
  import isa_ext_pkg::*;
#(
  parameter int unsigned      XLEN      = 32,
  parameter logic [EXT_W-1:0] SUPPORTED = 26'h1411B5,
  parameter logic [11:0]      ISA_ADDR  = 12'h301,
  parameter logic [11:0]      EPC_ADDR  = 12'h341
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [11:0]      csr_addr_i,
  input logic             csr_we_i,
  input logic [XLEN-1:0]  csr_rdata_o,
  input logic             pc_b1_i,
  input logic             hyp_access_i,
  input logic [EXT_W-1:0] ext_en_o,
  input logic             illegal_o
);
  // R2
  mxl_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_addr_i == ISA_ADDR |-> csr_rdata_o[XLEN-1 -: 2] == mxl_code(XLEN));

  // R3
  no_unsup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_en_o & ~SUPPORTED) == '0);

  // R5
  hyp_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hyp_access_i && !ext_en_o[EXT_H] |-> illegal_o);

  // R5
  hyp_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_en_o[EXT_H] |-> !illegal_o);

  // R6
  one_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({ext_en_o[EXT_I], ext_en_o[EXT_E]}) == 1);

  // R7
  c_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_we_i && csr_addr_i == ISA_ADDR && pc_b1_i && ext_en_o[EXT_C] |=> ext_en_o[EXT_C]);

  // R8
  epc_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_addr_i == EPC_ADDR && !ext_en_o[EXT_C] |-> csr_rdata_o[1:0] == 2'b00);

  // R10
  other_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_we_i && csr_addr_i != ISA_ADDR |=> $stable(ext_en_o));
endmodule

bind isa_ext_ctl isa_ext_ctl_chk #(
  .XLEN(XLEN), .SUPPORTED(SUPPORTED), .ISA_ADDR(ISA_ADDR), .EPC_ADDR(EPC_ADDR)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .csr_addr_i   (csr_addr_i),
  .csr_we_i     (csr_we_i),
  .csr_rdata_o  (csr_rdata_o),
  .pc_b1_i      (next_pc_i[1]),
  .hyp_access_i (hyp_access_i),
  .ext_en_o     (ext_en_o),
  .illegal_o    (illegal_o)
);

// File: tb/isa_ext_ctl_bench.sv
`timescale 1ns/1ps
module isa_ext_ctl_bench;
  localparam logic [11:0] A_ISA = 12'h301;
  localparam logic [11:0] A_EPC = 12'h341;
  localparam logic [11:0] A_OTH = 12'h340;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] npc = '0;
  logic        hyp = 1'b0;
  logic [25:0] ext_en;
  logic        illegal;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  isa_ext_ctl u_isa_ext_ctl (
    .clk_i(clk), .rst_ni(rst_n), .csr_addr_i(addr), .csr_we_i(we),
    .csr_wdata_i(wdata), .csr_rdata_o(rdata), .next_pc_i(npc),
    .hyp_access_i(hyp), .ext_en_o(ext_en), .illegal_o(illegal)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_ISA, d);
    chk("R1 reset isa", d, 32'h401411A5);
    chk("R1 reset ext_en", {6'd0, ext_en}, 32'h001411A5);
  endtask

  task automatic t_ro_bits();
    logic [31:0] d;
    wr(A_ISA, 32'h3FFFFFFF);
    rd(A_ISA, d);
    chk("R2 R3 all-ones write", d, 32'h401411A5);
    wr(A_ISA, 32'h00000002);
    rd(A_ISA, d);
    chk("R3 unsupported-only write", d, 32'h40000100);
  endtask

  task automatic t_write_bits();
    logic [31:0] d;
    wr(A_ISA, 32'h00001101);
    rd(A_ISA, d);
    chk("R4 read after write", d, 32'h40001101);
    chk("R4 ext_en after write", {6'd0, ext_en}, 32'h00001101);
  endtask

  task automatic t_hyp();
    wr(A_ISA, 32'h00141125);
    @(negedge clk); hyp = 1'b1; #1;
    chk("R5 H clear traps", {31'd0, illegal}, 32'd1);
    hyp = 1'b0; #1;
    chk("R5 no access no trap", {31'd0, illegal}, 32'd0);
    wr(A_ISA, 32'h001411A5);
    @(negedge clk); hyp = 1'b1; #1;
    chk("R5 H set no trap", {31'd0, illegal}, 32'd0);
    hyp = 1'b0;
  endtask

  task automatic t_base();
    logic [31:0] d;
    wr(A_ISA, 32'h001410B5);
    rd(A_ISA, d);
    chk("R6 E alone", d, 32'h401410B5);
    wr(A_ISA, 32'h001410A5);
    rd(A_ISA, d);
    chk("R6 neither keeps E", d, 32'h401410B5);
    wr(A_ISA, 32'h001411B5);
    rd(A_ISA, d);
    chk("R6 both picks I", d, 32'h401411A5);
  endtask

  task automatic t_c_align();
    logic [31:0] d;
    npc = 32'h00000102;
    wr(A_ISA, 32'h001411A1);
    rd(A_ISA, d);
    chk("R7 C kept on misaligned pc", d, 32'h401411A5);
    npc = 32'h00000104;
    wr(A_ISA, 32'h001411A1);
    rd(A_ISA, d);
    chk("R7 C cleared on aligned pc", d, 32'h401411A1);
    wr(A_ISA, 32'h001411A5);
    npc = '0;
  endtask

  task automatic t_epc();
    logic [31:0] d;
    wr(A_EPC, 32'h12345677);
    rd(A_EPC, d);
    chk("R8 bit0 zero with C", d, 32'h12345676);
    wr(A_ISA, 32'h001411A1);
    rd(A_EPC, d);
    chk("R8 bit1 hidden without C", d, 32'h12345674);
    wr(A_EPC, 32'h0000ABCE);
    rd(A_EPC, d);
    chk("R8 write while C off", d, 32'h0000ABCC);
    wr(A_ISA, 32'h001411A5);
    rd(A_EPC, d);
    chk("R9 bit1 restored", d, 32'h0000ABCE);
  endtask

  task automatic t_other();
    logic [31:0] d;
    wr(A_OTH, 32'h00000000);
    rd(A_ISA, d);
    chk("R10 isa unchanged", d, 32'h401411A5);
    rd(A_EPC, d);
    chk("R10 epc unchanged", d, 32'h0000ABCE);
    rd(A_OTH, d);
    chk("R10 other reads zero", d, 32'h00000000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ro_bits();
    t_write_bits();
    wr(A_ISA, 32'h001411A5);
    t_hyp();
    t_base();
    t_c_align();
    t_epc();
    t_other();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule